// File: doc/BRIEF.md
# Parallel-bus sampling converter host controller

This block sits on the host side of a 12-bit sampling converter that has a shared parallel data bus. It starts each conversion by driving an active-low convert-start strobe low for a set number of clocks. It then watches a synchronized copy of the converter's busy line, which falls for the length of the conversion and rises when the result may be read. After that it runs a read cycle with chip-select and read held low and returns the captured word on a one-cycle valid output. A conversion can be requested by a pulse or issued by an internal sample-rate timer. Requests that arrive while a cycle is running are held until the controller is idle again.

The same bus also carries offset words to the converter. A write cycle drives the word with the bus enable set, raises the write strobe for a set width, and holds the word for one more clock after the strobe falls, because the converter latches on that falling edge. Two result-timing modes are supported. In the immediate mode a read returns the conversion just finished. In the pipelined mode the converter moves a result into its output register only at the next convert-start, so every read returns the previous sample, and the first read after reset is flagged as stale. Standby and nap levels for the converter are registered from configuration inputs.

Top module: `adc_bus_host`

## Requirements
- R1: While reset is low: convert-start high, read high, write low, bus enable low, valid and done low, and chip-select high (low when chip-select is tied).
- R2: A convert request seen while idle drives `adc_convst_n` low for exactly CONV_W clocks. No read or write strobe is active during that window.
- R3: A convert request that arrives during a conversion, read or write cycle is held and starts one conversion once the controller is idle. Several requests that arrive before that conversion starts merge into one.
- R4: After convert-start returns high, the controller waits for the synchronized busy to fall and then rise, and only then drives `adc_cs_n` and `adc_rd_n` low. Read is never low while `adc_doe` is 1.
- R5: `adc_din` is captured RD_SMP clocks into the read strobe and presented on `smp_data` with `smp_valid` high for exactly one clock. Bit 11 is the MSB and is passed through unchanged.
- R6: With `cfg_pipelined` = 0, each sample equals the result of the conversion that just finished, and `smp_stale` is 0.
- R7: With `cfg_pipelined` = 1, the sample read after conversion k equals the result of conversion k-1. The first sample after reset carries `smp_stale` = 1 and all later samples carry 0.
- R8: An offset write drives `adc_dout` with `adc_doe` = 1 and chip-select low one clock before `adc_wr` rises. It holds `adc_wr` high for WR_W clocks and keeps the word and enable for one clock after `adc_wr` falls, so the converter latches the requested word.
- R9: Each accepted write produces exactly one one-clock `wr_done` pulse. A write starts only while idle, and a conversion pending at the same time goes first.
- R10: With parameter CS_TIED = 1, `adc_cs_n` stays 0 at all times and conversions and reads still return the correct samples.
- R11: `adc_stby` and `adc_nap` equal `cfg_standby` and `cfg_nap` one clock later.
- R12: With `cfg_rate_en` = 1, a convert request is issued every `cfg_rate_div` clocks, counted from when the enable was seen (divisor at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pipelined | input | 1 | 0 immediate result mode, 1 pipelined mode (static after reset) |
| cfg_rate_en | input | 1 | Enables the periodic sample-rate timer |
| cfg_rate_div | input | RATE_W | Sample period in clocks |
| cfg_standby | input | 1 | Requested standby level |
| cfg_nap | input | 1 | Requested nap level |
| conv_req | input | 1 | One-clock convert request |
| wr_req | input | 1 | One-clock offset write request |
| wr_word | input | DW | Offset word captured with wr_req |
| wr_done | output | 1 | One-clock pulse when a write cycle ends |
| smp_valid | output | 1 | One-clock sample strobe |
| smp_data | output | DW | Captured sample |
| smp_stale | output | 1 | Sample holds no real result (pipelined first read) |
| adc_convst_n | output | 1 | Convert-start strobe, active low |
| adc_busy | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr | output | 1 | Write strobe, active high, latched on its falling edge |
| adc_dout | output | DW | Word driven onto the bus |
| adc_doe | output | 1 | Bus drive enable for adc_dout |
| adc_din | input | DW | Word read from the bus |
| adc_stby | output | 1 | Standby level to the converter |
| adc_nap | output | 1 | Nap level to the converter |

## Verification
A corrupted sequencer state shows up at the converter pins within one conversion. Examples are a read strobe that overlaps the bus drive, a convert pulse of the wrong width, or a read issued before busy has risen. A stale or misordered result register shows up at the next `smp_valid` pulse as a word that does not match the expected conversion. In the pipelined mode this appears as a lag of zero or two samples instead of one. A lost or duplicated pending request shows up as a conversion count that differs from the number of request windows. A write data path fault shows up as a wrong offset word latched on the write falling edge.

// File: rtl/adc_bus_host_pkg.sv
package adc_bus_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_READ,
        ST_RD_END,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= ff_d;
    end

    assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/adc_rate_tick.sv
module adc_rate_tick #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] div,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_d, cnt_q;
    logic              at_end;

    assign at_end = (cnt_q == div - 1'b1);

    always_comb begin
        if (!en)         cnt_d = '0;
        else if (at_end) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && at_end;
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
    import adc_bus_host_pkg::*;
#(
    parameter int DW      = 12,
    parameter int CONV_W  = 4,
    parameter int RD_W    = 4,
    parameter int RD_SMP  = 2,
    parameter int WR_W    = 3,
    parameter int CS_TIED = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipelined,
    input  logic          standby_i,
    input  logic          nap_i,
    input  logic          conv_req,
    input  logic          tick,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_word,
    input  logic          busy_s,
    input  logic [DW-1:0] bus_in,
    output logic          convst_n,
    output logic          cs_n,
    output logic          rd_n,
    output logic          wr,
    output logic          oe,
    output logic [DW-1:0] bus_out,
    output logic          smp_valid,
    output logic [DW-1:0] smp_data,
    output logic          smp_stale,
    output logic          wr_done,
    output logic          stby,
    output logic          nap
);
    localparam int MAX_LEN = (CONV_W > RD_W) ? ((CONV_W > WR_W) ? CONV_W : WR_W)
                                              : ((RD_W > WR_W) ? RD_W : WR_W);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_W - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_W - 1);
    localparam logic [CNT_W-1:0] RD_AT     = CNT_W'(RD_SMP);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_W - 1);
    localparam logic             CS_IDLE   = (CS_TIED == 0);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             conv_pend;
        logic             wr_pend;
        logic [DW-1:0]    wr_word;
        logic             convst_n;
        logic             cs_n;
        logic             rd_n;
        logic             wr;
        logic             oe;
        logic [DW-1:0]    dout;
        logic             smp_valid;
        logic [DW-1:0]    smp_data;
        logic             smp_stale;
        logic             first;
        logic             wr_done;
        logic             stby;
        logic             nap;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state:     ST_IDLE,
        cnt:       '0,
        conv_pend: 1'b0,
        wr_pend:   1'b0,
        wr_word:   '0,
        convst_n:  1'b1,
        cs_n:      CS_IDLE,
        rd_n:      1'b1,
        wr:        1'b0,
        oe:        1'b0,
        dout:      '0,
        smp_valid: 1'b0,
        smp_data:  '0,
        smp_stale: 1'b0,
        first:     1'b1,
        wr_done:   1'b0,
        stby:      1'b0,
        nap:       1'b0
    };

    seq_t q, d;

    always_comb begin
        d           = q;
        d.smp_valid = 1'b0;
        d.wr_done   = 1'b0;
        d.stby      = standby_i;
        d.nap       = nap_i;

        unique case (q.state)
            ST_IDLE: begin
                // a pending conversion outranks a pending write
                if (q.conv_pend) begin
                    d.state     = ST_CONV;
                    d.cnt       = '0;
                    d.convst_n  = 1'b0;
                    d.conv_pend = 1'b0;
                end else if (q.wr_pend) begin
                    d.state   = ST_WR_SETUP;
                    d.cs_n    = 1'b0;
                    d.oe      = 1'b1;
                    d.dout    = q.wr_word;
                    d.wr_pend = 1'b0;
                end
            end
            ST_CONV: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CONV_LAST) begin
                    d.convst_n = 1'b1;
                    d.state    = ST_WAIT_LO;
                end
            end
            ST_WAIT_LO: begin
                if (!busy_s) d.state = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (busy_s) begin
                    d.state = ST_READ;
                    d.cnt   = '0;
                    d.cs_n  = 1'b0;
                    d.rd_n  = 1'b0;
                end
            end
            ST_READ: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == RD_AT) begin
                    d.smp_data  = bus_in;
                    d.smp_valid = 1'b1;
                    d.smp_stale = pipelined && q.first;
                    d.first     = 1'b0;
                end
                if (q.cnt == RD_LAST) begin
                    d.rd_n  = 1'b1;
                    d.state = ST_RD_END;
                end
            end
            ST_RD_END: begin
                d.cs_n  = 1'b1;
                d.state = ST_IDLE;
            end
            ST_WR_SETUP: begin
                d.wr    = 1'b1;
                d.cnt   = '0;
                d.state = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == WR_LAST) begin
                    d.wr    = 1'b0;
                    d.state = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                d.oe      = 1'b0;
                d.cs_n    = 1'b1;
                d.wr_done = 1'b1;
                d.state   = ST_IDLE;
            end
            default: d = SEQ_RST;
        endcase

        if (conv_req || tick) d.conv_pend = 1'b1;
        if (wr_req && !q.wr_pend) begin
            d.wr_pend = 1'b1;
            d.wr_word = wr_word;
        end
        if (CS_TIED != 0) d.cs_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign convst_n  = q.convst_n;
    assign cs_n      = q.cs_n;
    assign rd_n      = q.rd_n;
    assign wr        = q.wr;
    assign oe        = q.oe;
    assign bus_out   = q.dout;
    assign smp_valid = q.smp_valid;
    assign smp_data  = q.smp_data;
    assign smp_stale = q.smp_stale;
    assign wr_done   = q.wr_done;
    assign stby      = q.stby;
    assign nap       = q.nap;
endmodule

// File: rtl/adc_bus_host.sv
module adc_bus_host #(
    parameter int DW          = 12,
    parameter int RATE_W      = 16,
    parameter int CONV_W      = 4,
    parameter int RD_W        = 4,
    parameter int RD_SMP      = 2,
    parameter int WR_W        = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CS_TIED     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pipelined,
    input  logic              cfg_rate_en,
    input  logic [RATE_W-1:0] cfg_rate_div,
    input  logic              cfg_standby,
    input  logic              cfg_nap,
    input  logic              conv_req,
    input  logic              wr_req,
    input  logic [DW-1:0]     wr_word,
    output logic              wr_done,
    output logic              smp_valid,
    output logic [DW-1:0]     smp_data,
    output logic              smp_stale,
    output logic              adc_convst_n,
    input  logic              adc_busy,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_wr,
    output logic [DW-1:0]     adc_dout,
    output logic              adc_doe,
    input  logic [DW-1:0]     adc_din,
    output logic              adc_stby,
    output logic              adc_nap
);
    logic busy_s;
    logic rate_tick;

    adc_busy_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (adc_busy),
        .sync_o  (busy_s)
    );

    adc_rate_tick #(
        .RATE_W (RATE_W)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_rate_en),
        .div   (cfg_rate_div),
        .tick  (rate_tick)
    );

    adc_bus_seq #(
        .DW      (DW),
        .CONV_W  (CONV_W),
        .RD_W    (RD_W),
        .RD_SMP  (RD_SMP),
        .WR_W    (WR_W),
        .CS_TIED (CS_TIED)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipelined (cfg_pipelined),
        .standby_i (cfg_standby),
        .nap_i     (cfg_nap),
        .conv_req  (conv_req),
        .tick      (rate_tick),
        .wr_req    (wr_req),
        .wr_word   (wr_word),
        .busy_s    (busy_s),
        .bus_in    (adc_din),
        .convst_n  (adc_convst_n),
        .cs_n      (adc_cs_n),
        .rd_n      (adc_rd_n),
        .wr        (adc_wr),
        .oe        (adc_doe),
        .bus_out   (adc_dout),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_stale (smp_stale),
        .wr_done   (wr_done),
        .stby      (adc_stby),
        .nap       (adc_nap)
    );
endmodule

// File: rtl/adc_bus_host_chk.sv
module adc_bus_host_chk #(
    parameter int DW      = 12,
    parameter int CONV_W  = 4,
    parameter int CS_TIED = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_pipelined,
    input logic          cfg_standby,
    input logic          cfg_nap,
    input logic          smp_valid,
    input logic          smp_stale,
    input logic          wr_done,
    input logic          adc_convst_n,
    input logic          adc_cs_n,
    input logic          adc_rd_n,
    input logic          adc_wr,
    input logic          adc_doe,
    input logic [DW-1:0] adc_dout,
    input logic          adc_stby,
    input logic          adc_nap
);
    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            lo_cnt <= '0;
        else if (!adc_convst_n) lo_cnt <= lo_cnt + 1'b1;
        else                   lo_cnt <= '0;
    end

    p_conv_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst_n) |-> lo_cnt == 16'(CONV_W));

    p_conv_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_convst_n |-> adc_rd_n && !adc_wr);

    p_rd_bus_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_doe);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    p_no_stale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !cfg_pipelined |-> !smp_stale);

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_wr) |-> adc_doe && $stable(adc_dout) && !adc_cs_n);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    p_stby_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> adc_stby == $past(cfg_standby));

    p_nap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> adc_nap == $past(cfg_nap));

    if (CS_TIED != 0) begin : g_tied
        p_cs_tied_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !adc_cs_n);
    end
endmodule

bind adc_bus_host adc_bus_host_chk #(
    .DW      (DW),
    .CONV_W  (CONV_W),
    .CS_TIED (CS_TIED)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pipelined (cfg_pipelined),
    .cfg_standby   (cfg_standby),
    .cfg_nap       (cfg_nap),
    .smp_valid     (smp_valid),
    .smp_stale     (smp_stale),
    .wr_done       (wr_done),
    .adc_convst_n  (adc_convst_n),
    .adc_cs_n      (adc_cs_n),
    .adc_rd_n      (adc_rd_n),
    .adc_wr        (adc_wr),
    .adc_doe       (adc_doe),
    .adc_dout      (adc_dout),
    .adc_stby      (adc_stby),
    .adc_nap       (adc_nap)
);

// File: tb/tb_adc_bus_host.sv
module tb_adc_model #(
    parameter int DW  = 12,
    parameter int LAT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipelined,
    input  logic          convst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr,
    input  logic [DW-1:0] dout,
    input  logic          doe,
    output logic          busy,
    output logic [DW-1:0] din,
    output int            conv_cnt,
    output int            low_w,
    output logic [DW-1:0] offset,
    output int            off_conv
);
    function automatic logic [DW-1:0] sval(int k);
        return DW'(k * 2535 + 2138);
    endfunction

    logic          cv_prev, wr_prev;
    int            lat, lo;
    logic [DW-1:0] outreg, pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b1; cv_prev <= 1'b1; wr_prev <= 1'b0; lat <= 0; lo <= 0;
            outreg <= 12'h3C3; pend <= 12'h3C3; conv_cnt <= 0; low_w <= 0;
            offset <= '0; off_conv <= 0;
        end else begin
            cv_prev <= convst_n;
            wr_prev <= wr;
            if (!convst_n) lo <= lo + 1;
            else begin
                if (lo != 0) low_w <= lo;
                lo <= 0;
            end
            if (cv_prev && !convst_n) begin
                busy <= 1'b0;
                lat  <= 0;
                if (pipelined) outreg <= pend;
            end else if (!busy) begin
                if (lat == LAT - 1) begin
                    busy <= 1'b1;
                    if (pipelined) pend <= sval(conv_cnt);
                    else           outreg <= sval(conv_cnt);
                    conv_cnt <= conv_cnt + 1;
                end else lat <= lat + 1;
            end
            if (wr_prev && !wr && !cs_n) begin
                offset   <= doe ? dout : 12'hFFF;
                off_conv <= conv_cnt;
            end
        end
    end

    assign din = (!cs_n && !rd_n) ? outreg : '0;
endmodule

module tb_adc_bus_host;
    localparam int DW     = 12;
    localparam int CONV_W = 4;
    localparam int LAT    = 20;

    function automatic logic [DW-1:0] sval(int k);
        return DW'(k * 2535 + 2138);
    endfunction

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pipelined = 1'b0, rate_en = 1'b0, standby = 1'b0, nap = 1'b0;
    logic [15:0]   rate_div = 16'd200;
    logic          conv_req = 1'b0, wr_req = 1'b0;
    logic [DW-1:0] wr_word = '0;
    logic          wr_done, smp_valid, smp_stale, convst_n, busy, cs_n, rd_n, wr, doe, a_stby, a_nap;
    logic [DW-1:0] smp_data, dout, din;
    int            m_cnt, m_low, m_offc;
    logic [DW-1:0] m_off;

    adc_bus_host #(.CONV_W(CONV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_pipelined(pipelined), .cfg_rate_en(rate_en),
        .cfg_rate_div(rate_div), .cfg_standby(standby), .cfg_nap(nap),
        .conv_req(conv_req), .wr_req(wr_req), .wr_word(wr_word), .wr_done(wr_done),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_stale(smp_stale),
        .adc_convst_n(convst_n), .adc_busy(busy), .adc_cs_n(cs_n), .adc_rd_n(rd_n),
        .adc_wr(wr), .adc_dout(dout), .adc_doe(doe), .adc_din(din),
        .adc_stby(a_stby), .adc_nap(a_nap));

    tb_adc_model #(.DW(DW), .LAT(LAT)) m_main (
        .clk(clk), .rst_n(rst_n), .pipelined(pipelined), .convst_n(convst_n),
        .cs_n(cs_n), .rd_n(rd_n), .wr(wr), .dout(dout), .doe(doe), .busy(busy),
        .din(din), .conv_cnt(m_cnt), .low_w(m_low), .offset(m_off), .off_conv(m_offc));

    // second instance with chip-select tied active
    logic          c_req = 1'b0;
    logic          c_done, c_valid, c_stale, c_convst_n, c_busy, c_cs_n, c_rd_n, c_wr, c_doe, c_stby, c_nap;
    logic [DW-1:0] c_data, c_dout, c_din;
    int            c_mcnt, c_mlow, c_moffc;
    logic [DW-1:0] c_moff;

    adc_bus_host #(.CONV_W(CONV_W), .CS_TIED(1)) dut_cs (
        .clk(clk), .rst_n(rst_n), .cfg_pipelined(1'b0), .cfg_rate_en(1'b0),
        .cfg_rate_div(16'd0), .cfg_standby(1'b0), .cfg_nap(1'b0),
        .conv_req(c_req), .wr_req(1'b0), .wr_word(12'h000), .wr_done(c_done),
        .smp_valid(c_valid), .smp_data(c_data), .smp_stale(c_stale),
        .adc_convst_n(c_convst_n), .adc_busy(c_busy), .adc_cs_n(c_cs_n), .adc_rd_n(c_rd_n),
        .adc_wr(c_wr), .adc_dout(c_dout), .adc_doe(c_doe), .adc_din(c_din),
        .adc_stby(c_stby), .adc_nap(c_nap));

    tb_adc_model #(.DW(DW), .LAT(LAT)) m_cs (
        .clk(clk), .rst_n(rst_n), .pipelined(1'b0), .convst_n(c_convst_n),
        .cs_n(c_cs_n), .rd_n(c_rd_n), .wr(c_wr), .dout(c_dout), .doe(c_doe), .busy(c_busy),
        .din(c_din), .conv_cnt(c_mcnt), .low_w(c_mlow), .offset(c_moff), .off_conv(c_moffc));

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard: expected item pushed at every convert-start fall
    logic [DW:0] exp_q[$];
    int          k_conv = 0;

    always @(negedge convst_n) begin
        if (rst_n) begin
            if (!pipelined)      exp_q.push_back({1'b0, sval(k_conv)});
            else if (k_conv == 0) exp_q.push_back({1'b1, 12'h000});
            else                 exp_q.push_back({1'b0, sval(k_conv - 1)});
            k_conv++;
        end
    end

    int  done_cnt = 0;
    bit  rd_bad = 0, cs_high_seen = 0;
    int  c_k = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid) begin
                if (exp_q.size() == 0) chk(0, "R5 sample without conversion", smp_data, 0);
                else begin
                    logic [DW:0] e;
                    e = exp_q.pop_front();
                    if (e[DW]) chk(smp_stale == 1'b1, "R7 first pipelined read stale", smp_stale, 1);
                    else chk(smp_stale == 1'b0 && smp_data == e[DW-1:0],
                             pipelined ? "R7 R5 lagged sample" : "R6 R5 sample",
                             {smp_stale, smp_data}, {1'b0, e[DW-1:0]});
                end
            end
            if (wr_done) done_cnt++;
            if (!rd_n && (!busy || doe)) rd_bad = 1;
            if (c_cs_n) cs_high_seen = 1;
            if (c_valid) begin
                chk(c_data == sval(c_k), "R10 tied chip-select sample", c_data, sval(c_k));
                c_k++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_conv();
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
    endtask

    task automatic do_write(input logic [DW-1:0] w, input bit with_conv);
        @(negedge clk) begin wr_req = 1'b1; wr_word = w; conv_req = with_conv; end
        @(negedge clk) begin wr_req = 1'b0; conv_req = 1'b0; end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        pipelined = mode;
        tick(3);
        chk(convst_n == 1'b1, "R1 convst_n in reset", convst_n, 1);
        chk(cs_n == 1'b1 && rd_n == 1'b1, "R1 cs_n/rd_n in reset", {cs_n, rd_n}, 2'b11);
        chk(wr == 1'b0 && doe == 1'b0, "R1 wr/doe in reset", {wr, doe}, 0);
        chk(smp_valid == 1'b0 && wr_done == 1'b0, "R1 valid/done in reset", {smp_valid, wr_done}, 0);
        chk(c_cs_n == 1'b0, "R1 tied cs_n in reset", c_cs_n, 0);
        exp_q.delete();
        k_conv = 0;
        c_k = 0;
        rst_n = 1'b1;
        tick(2);
    endtask

    initial begin
        int c0;
        do_reset(1'b0);

        // immediate mode, single conversions
        for (int i = 0; i < 4; i++) begin
            pulse_conv();
            tick(80);
        end
        chk(m_low == CONV_W, "R2 convst low width", m_low, CONV_W);
        chk(k_conv == 4, "R2 one conversion per request", k_conv, 4);

        // held and merged requests
        c0 = k_conv;
        pulse_conv();
        tick(8);
        pulse_conv();
        tick(3);
        pulse_conv();
        tick(200);
        chk(k_conv == c0 + 2, "R3 held requests merge", k_conv, c0 + 2);

        // offset writes
        done_cnt = 0;
        do_write(12'hA5C, 1'b0);
        tick(30);
        chk(m_off == 12'hA5C, "R8 offset word latched", m_off, 12'hA5C);
        chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
        do_write(12'h3F0, 1'b0);
        tick(30);
        chk(m_off == 12'h3F0, "R8 second offset word", m_off, 12'h3F0);
        c0 = m_cnt;
        done_cnt = 0;
        do_write(12'h801, 1'b1);
        tick(120);
        chk(m_offc == c0 + 1, "R9 conversion goes before write", m_offc, c0 + 1);
        chk(m_off == 12'h801 && done_cnt == 1, "R9 R8 write after conversion", {done_cnt[3:0], m_off}, {4'd1, 12'h801});

        // power levels
        @(negedge clk) standby = 1'b1;
        @(negedge clk) chk(a_stby == 1'b1, "R11 standby follows", a_stby, 1);
        nap = 1'b1;
        standby = 1'b0;
        @(negedge clk) chk(a_nap == 1'b1 && a_stby == 1'b0, "R11 nap follows", {a_nap, a_stby}, 2'b10);
        nap = 1'b0;
        tick(2);

        // periodic timer
        c0 = k_conv;
        rate_div = 16'd200;
        @(negedge clk) rate_en = 1'b1;
        tick(10 * 200 + 60);
        rate_en = 1'b0;
        tick(100);
        chk(k_conv == c0 + 10, "R12 rate timer count", k_conv, c0 + 10);
        chk(exp_q.size() == 0, "R5 every conversion read (immediate)", exp_q.size(), 0);

        // tied chip-select instance
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) c_req = 1'b1;
            @(negedge clk) c_req = 1'b0;
            tick(80);
        end
        chk(c_k == 3, "R10 tied chip-select read count", c_k, 3);
        chk(!cs_high_seen, "R10 chip-select stayed low", cs_high_seen, 0);

        // pipelined mode
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) begin
            pulse_conv();
            tick(80);
        end
        chk(k_conv == 5, "R7 pipelined conversions", k_conv, 5);
        chk(exp_q.size() == 0, "R7 every pipelined conversion read", exp_q.size(), 0);
        chk(!rd_bad, "R4 read only after busy high with bus released", rd_bad, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule